// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the effective memory address of a load or store and decides whether the base register is updated, and with what value. It accepts the base register value, an index register value and a displacement that has already been sign-extended. It also takes a two-bit form code, the access size and the two modify-control bits carried in the instruction word. For one transaction it produces the address to present to memory, a base-writeback enable with its value, and a flag that tells the register file how to order the writes.

There are four forms. In the indexed form the offset is the index value, shifted left by the access size when the scale bit is set. In the short-displacement form the two control bits select one of three actions: no update, update before the access, or update after the access. The two long-displacement forms take that choice from the sign of the displacement, and the two forms use opposite polarity. All of this logic is combinational. One register stage holds the results, so they appear one clock after the request.

Top module: `agu_top`

## Requirements
- R1: While reset is active, and in the first cycle after it, out_valid, wb_en and load_after_wb are 0.
- R2: For a displacement form with no base update, acc_addr equals base_val + disp (wrapping at the address width) one clock after in_valid, and wb_en is 0.
- R3: In the indexed form (form = 0), the offset is index_val shifted left by size when a_bit is 1, and by 0 when a_bit is 0.
- R4: In the short form (form = 1): m_bit = 0 means no update; m_bit = 1 with a_bit = 1 means pre-update; m_bit = 1 with a_bit = 0 means post-update.
- R5: A pre-update access or an access with no update uses the computed address. A post-update access uses base_val unchanged.
- R6: Any update sets wb_en to 1, and wb_val is then the computed address (base plus offset).
- R7: In the long form (form = 2) with m_bit = 1, a negative disp (top bit set) selects pre-update and a non-negative disp, zero included, selects post-update. With m_bit = 0 there is no update.
- R8: In the alternate long form (form = 3) with m_bit = 1, a negative disp selects post-update and a non-negative disp selects pre-update. With m_bit = 0 there is no update.
- R9: In the indexed form, m_bit = 1 selects post-update and m_bit = 0 selects no update.
- R10: load_after_wb is 1 only when is_load is 1, an update takes place and tgt_reg equals base_reg. It is never 1 for a store.
- R11: A cycle with in_valid = 0 gives out_valid, wb_en and load_after_wb all 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| form | input | 2 | 0 indexed, 1 short disp, 2 long disp, 3 alternate long disp |
| is_load | input | 1 | 1 for a load, 0 for a store |
| m_bit | input | 1 | Modify request |
| a_bit | input | 1 | Pre/post select (short form) or scale enable (indexed form) |
| size | input | SIZE_W | Access size code, log2 of bytes |
| tgt_reg | input | REG_W | Load target register number |
| base_reg | input | REG_W | Base register number |
| base_val | input | ADDR_W | Base register contents |
| index_val | input | ADDR_W | Index register contents |
| disp | input | ADDR_W | Sign-extended displacement |
| out_valid | output | 1 | Registered results valid |
| acc_addr | output | ADDR_W | Address presented to memory |
| wb_en | output | 1 | Base register writeback enable |
| wb_val | output | ADDR_W | New base register value |
| load_after_wb | output | 1 | Register file must apply the load result after the base update |

## Verification
The base writeback and the load result can land on the same register in one transaction. This happens when a modifying load names the same register as both target and base. The bench provokes it with directed loads that use pre-update and post-update and share the register number, and with random register numbers drawn from a small range so that collisions recur. In each case it checks that load_after_wb and wb_en are set together, that wb_val holds the updated base, and that the identical store leaves the flag clear.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      FORM_INDEXED  = 2'd0,
      FORM_SHORT    = 2'd1,
      FORM_LONG     = 2'd2,
      FORM_LONG_ALT = 2'd3
   } agu_form_t;

   typedef enum logic [1:0] {
      UPD_NONE = 2'd0,
      UPD_PRE  = 2'd1,
      UPD_POST = 2'd2
   } agu_upd_t;
endpackage

// File: rtl/agu_upd_dec.sv
module agu_upd_dec
   import agu_pkg::*;
(
   input  agu_form_t form,
   input  logic      m_bit,
   input  logic      a_bit,
   input  logic      disp_neg,
   output agu_upd_t  upd,
   output logic      use_index
);
   always_comb begin
      upd       = UPD_NONE;
      use_index = 1'b0;
      unique case (form)
         FORM_INDEXED: begin
            use_index = 1'b1;
            upd       = m_bit ? UPD_POST : UPD_NONE;
         end
         FORM_SHORT: begin
            if (m_bit) upd = a_bit ? UPD_PRE : UPD_POST;
         end
         FORM_LONG: begin
            if (m_bit) upd = disp_neg ? UPD_PRE : UPD_POST;
         end
         FORM_LONG_ALT: begin
            if (m_bit) upd = disp_neg ? UPD_POST : UPD_PRE;
         end
         default: upd = UPD_NONE;
      endcase
   end
endmodule

// File: rtl/agu_offset.sv
module agu_offset #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] index_val,
   input  logic [ADDR_W-1:0] disp,
   input  logic [SIZE_W-1:0] size,
   input  logic              a_bit,
   input  logic              use_index,
   output logic [ADDR_W-1:0] offset
);
   localparam int NSCALE = 1 << SIZE_W;

   logic [ADDR_W-1:0] shifted [NSCALE];
   logic [SIZE_W-1:0] scale;

   for (genvar k = 0; k < NSCALE; k++) begin : g_shift
      assign shifted[k] = index_val << k;
   end

   assign scale  = a_bit ? size : '0;
   assign offset = use_index ? shifted[scale] : disp;
endmodule

// File: rtl/agu_top.sv
module agu_top
   import agu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2,
   parameter int REG_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        form,
   input  logic              is_load,
   input  logic              m_bit,
   input  logic              a_bit,
   input  logic [SIZE_W-1:0] size,
   input  logic [REG_W-1:0]  tgt_reg,
   input  logic [REG_W-1:0]  base_reg,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] index_val,
   input  logic [ADDR_W-1:0] disp,
   output logic              out_valid,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              wb_en,
   output logic [ADDR_W-1:0] wb_val,
   output logic              load_after_wb
);
   if (ADDR_W < 8 || SIZE_W < 1 || SIZE_W > 3 || REG_W < 1) begin : g_bad_param
      $error("agu_top: parameter out of supported range");
   end

   agu_upd_t          upd;
   logic              use_index;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] calc_addr;
   logic [ADDR_W-1:0] pick_addr;
   logic              do_upd;
   logic              same_reg;

   agu_upd_dec u_dec (
      .form      (agu_form_t'(form)),
      .m_bit     (m_bit),
      .a_bit     (a_bit),
      .disp_neg  (disp[ADDR_W-1]),
      .upd       (upd),
      .use_index (use_index)
   );

   agu_offset #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_off (
      .index_val (index_val),
      .disp      (disp),
      .size      (size),
      .a_bit     (a_bit),
      .use_index (use_index),
      .offset    (offset)
   );

   assign calc_addr = base_val + offset;
   assign pick_addr = (upd == UPD_POST) ? base_val : calc_addr;
   assign do_upd    = (upd != UPD_NONE);
   assign same_reg  = (tgt_reg == base_reg);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         acc_addr      <= '0;
         wb_en         <= 1'b0;
         wb_val        <= '0;
         load_after_wb <= 1'b0;
      end else begin
         out_valid     <= in_valid;
         acc_addr      <= pick_addr;
         wb_en         <= in_valid && do_upd;
         wb_val        <= calc_addr;
         load_after_wb <= in_valid && do_upd && is_load && same_reg;
      end
   end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        form,
   input logic              is_load,
   input logic              m_bit,
   input logic              a_bit,
   input logic [ADDR_W-1:0] base_val,
   input logic [ADDR_W-1:0] disp,
   input logic              out_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              wb_en,
   input logic [ADDR_W-1:0] wb_val,
   input logic              load_after_wb
);
   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!wb_en && !load_after_wb));

   assert_flag_needs_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load_after_wb |-> wb_en);

   assert_store_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && !$past(is_load)) |-> !load_after_wb);

   assert_short_nomod_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(form) == 2'd1 && !$past(m_bit))
      |-> (!wb_en && acc_addr == $past(base_val) + $past(disp)));

   assert_short_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(form) == 2'd1 && $past(m_bit) && $past(a_bit))
      |-> (wb_en && acc_addr == wb_val));

   assert_short_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(form) == 2'd1 && $past(m_bit) && !$past(a_bit))
      |-> (wb_en && acc_addr == $past(base_val)));

   assert_long_neg_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(form) == 2'd2 && $past(m_bit) && $past(disp[ADDR_W-1]))
      |-> (wb_en && acc_addr == wb_val));

   assert_alt_neg_post_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(form) == 2'd3 && $past(m_bit) && $past(disp[ADDR_W-1]))
      |-> (wb_en && acc_addr == $past(base_val)));

   assert_wb_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(form) != 2'd0 && $past(m_bit))
      |-> (wb_val == $past(base_val) + $past(disp)));
endmodule

bind agu_top agu_checker #(.ADDR_W(ADDR_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .form          (form),
   .is_load       (is_load),
   .m_bit         (m_bit),
   .a_bit         (a_bit),
   .base_val      (base_val),
   .disp          (disp),
   .out_valid     (out_valid),
   .acc_addr      (acc_addr),
   .wb_en         (wb_en),
   .wb_val        (wb_val),
   .load_after_wb (load_after_wb)
);

// File: tb/agu_top_tb.sv
module agu_top_tb_top;
   localparam int W  = 32;
   localparam int SW = 2;
   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    form = '0;
   logic          is_load = 1'b0;
   logic          m_bit = 1'b0;
   logic          a_bit = 1'b0;
   logic [SW-1:0] size = '0;
   logic [RW-1:0] tgt_reg = '0;
   logic [RW-1:0] base_reg = '0;
   logic [W-1:0]  base_val = '0;
   logic [W-1:0]  index_val = '0;
   logic [W-1:0]  disp = '0;
   logic          out_valid;
   logic [W-1:0]  acc_addr;
   logic          wb_en;
   logic [W-1:0]  wb_val;
   logic          load_after_wb;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   agu_top #(.ADDR_W(W), .SIZE_W(SW), .REG_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form(form),
      .is_load(is_load), .m_bit(m_bit), .a_bit(a_bit), .size(size),
      .tgt_reg(tgt_reg), .base_reg(base_reg), .base_val(base_val),
      .index_val(index_val), .disp(disp), .out_valid(out_valid),
      .acc_addr(acc_addr), .wb_en(wb_en), .wb_val(wb_val),
      .load_after_wb(load_after_wb)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // upd: 0 none, 1 pre, 2 post
   task automatic model(output logic [W-1:0] ea, output logic we,
                        output logic [W-1:0] wv, output logic fl);
      logic [W-1:0] off;
      int upd;
      off = disp;
      upd = 0;
      case (form)
         2'd0: begin
            off = index_val << (a_bit ? int'(size) : 0);
            upd = m_bit ? 2 : 0;
         end
         2'd1: upd = !m_bit ? 0 : (a_bit ? 1 : 2);
         2'd2: upd = !m_bit ? 0 : (disp[W-1] ? 1 : 2);
         default: upd = !m_bit ? 0 : (disp[W-1] ? 2 : 1);
      endcase
      wv = base_val + off;
      ea = (upd == 2) ? base_val : wv;
      we = (upd != 0);
      fl = is_load && we && (tgt_reg == base_reg);
   endtask

   function automatic string form_req(input logic [1:0] f);
      case (f)
         2'd0: return "R3_R9";
         2'd1: return "R4_R5";
         2'd2: return "R7";
         default: return "R8";
      endcase
   endfunction

   // inputs already set; called just after a negedge
   task automatic run_one();
      logic [W-1:0] ea, wv;
      logic we, fl;
      in_valid = 1'b1;
      model(ea, we, wv, fl);
      @(negedge clk);
      chk("R11 out_valid", W'(out_valid), W'(1));
      chk(form_req(form), acc_addr, ea);
      chk("R6 wb_en", W'(wb_en), W'(we));
      if (we) chk("R6 wb_val", wb_val, wv);
      chk("R10 load_after_wb", W'(load_after_wb), W'(fl));
   endtask

   task automatic setup(input logic [1:0] f, input logic ld, input logic m, input logic a,
                        input logic [SW-1:0] sz, input logic [RW-1:0] t, input logic [RW-1:0] b,
                        input logic [W-1:0] bv, input logic [W-1:0] iv, input logic [W-1:0] dv);
      form = f; is_load = ld; m_bit = m; a_bit = a; size = sz;
      tgt_reg = t; base_reg = b; base_val = bv; index_val = iv; disp = dv;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5EED_0A61);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 out_valid", W'(out_valid), W'(0));
      chk("R1 wb_en", W'(wb_en), W'(0));
      chk("R1 load_after_wb", W'(load_after_wb), W'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 post-reset wb_en", W'(wb_en), W'(0));

      // R2: short form, no update, with wrap-around
      setup(2'd1, 1'b0, 1'b0, 1'b1, 2'd2, 5'd3, 5'd4, 32'hFFFF_FFF0, '0, 32'h20);
      run_one();
      chk("R2 addr wrap", acc_addr, 32'h0000_0010);
      // R4/R5: short pre, short post
      setup(2'd1, 1'b1, 1'b1, 1'b1, 2'd2, 5'd1, 5'd2, 32'h1000, '0, 32'hFFFF_FFFC);
      run_one();
      chk("R4 pre addr", acc_addr, 32'h0FFC);
      setup(2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 5'd1, 5'd2, 32'h1000, '0, 32'h8);
      run_one();
      chk("R5 post uses base", acc_addr, 32'h1000);
      chk("R6 post wb", wb_val, 32'h1008);
      // R3: indexed scaled by size 3, and unscaled
      setup(2'd0, 1'b1, 1'b0, 1'b1, 2'd3, 5'd1, 5'd2, 32'h100, 32'h3, '0);
      run_one();
      chk("R3 scaled", acc_addr, 32'h118);
      setup(2'd0, 1'b1, 1'b0, 1'b0, 2'd3, 5'd1, 5'd2, 32'h100, 32'h3, '0);
      run_one();
      chk("R3 unscaled", acc_addr, 32'h103);
      // R9: indexed with modify is post
      setup(2'd0, 1'b0, 1'b1, 1'b1, 2'd1, 5'd1, 5'd2, 32'h200, 32'h4, '0);
      run_one();
      chk("R9 post addr", acc_addr, 32'h200);
      chk("R9 wb", wb_val, 32'h208);
      // R7: long, negative pre, zero post
      setup(2'd2, 1'b0, 1'b1, 1'b0, 2'd2, 5'd1, 5'd2, 32'h400, '0, 32'hFFFF_FFF0);
      run_one();
      chk("R7 neg pre", acc_addr, 32'h3F0);
      setup(2'd2, 1'b0, 1'b1, 1'b0, 2'd2, 5'd1, 5'd2, 32'h400, '0, 32'h0);
      run_one();
      chk("R7 zero post wb_en", W'(wb_en), W'(1));
      // R8: alternate long, negative post, positive pre
      setup(2'd3, 1'b0, 1'b1, 1'b0, 2'd2, 5'd1, 5'd2, 32'h400, '0, 32'hFFFF_FFF0);
      run_one();
      chk("R8 neg post", acc_addr, 32'h400);
      setup(2'd3, 1'b0, 1'b1, 1'b0, 2'd2, 5'd1, 5'd2, 32'h400, '0, 32'h10);
      run_one();
      chk("R8 pos pre", acc_addr, 32'h410);
      setup(2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 5'd7, 5'd7, 32'h400, '0, 32'hFFFF_FFF0);
      run_one();
      chk("R8 no modify flag", W'(load_after_wb), W'(0));
      // R10: same register, load vs store, pre and post
      setup(2'd1, 1'b1, 1'b1, 1'b1, 2'd2, 5'd9, 5'd9, 32'h800, '0, 32'h4);
      run_one();
      chk("R10 load pre same reg", W'(load_after_wb), W'(1));
      setup(2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 5'd9, 5'd9, 32'h800, '0, 32'h4);
      run_one();
      chk("R10 load post same reg", W'(load_after_wb), W'(1));
      setup(2'd1, 1'b0, 1'b1, 1'b1, 2'd2, 5'd9, 5'd9, 32'h800, '0, 32'h4);
      run_one();
      chk("R10 store same reg", W'(load_after_wb), W'(0));
      // R11: idle cycle with modifying inputs present
      in_valid = 1'b0;
      setup(2'd1, 1'b1, 1'b1, 1'b1, 2'd2, 5'd9, 5'd9, 32'h800, '0, 32'h4);
      @(negedge clk);
      chk("R11 idle valid", W'(out_valid), W'(0));
      chk("R11 idle wb_en", W'(wb_en), W'(0));
      chk("R11 idle flag", W'(load_after_wb), W'(0));

      // constrained random, registers drawn from 0..3 so collisions recur
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] d;
         d = $urandom();
         if ($urandom_range(0, 3) == 0) d = W'($signed($urandom_range(0, 63)) - 32);
         setup(2'($urandom_range(0, 3)), 1'($urandom()), 1'($urandom()), 1'($urandom()),
               SW'($urandom()), RW'($urandom_range(0, 3)), RW'($urandom_range(0, 3)),
               $urandom(), $urandom(), d);
         if ($urandom_range(0, 7) == 0) begin
            in_valid = 1'b0;
            @(negedge clk);
            chk("R11 random idle", W'(wb_en), W'(0));
         end else begin
            run_one();
         end
      end
      in_valid = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule